// File: doc/BRIEF.md
# Shared-Adder 32-bit Integer ALU

This block is the combinational arithmetic and logic unit of a small RISC-style integer core. It takes two 32-bit operands and a 3-bit operation code. It returns a 32-bit result and a flag that reports when that result is zero. It has no clock and holds no state. The enclosing pipeline registers its inputs and its outputs.

Addition, subtraction and signed less-than comparison all pass through one ripple-carry adder. The adder is a chain of full-adder cells, and each cell is built from two half adders. To subtract, the block inverts the second operand and forces the carry into the first stage high. The comparison looks at the sign of that difference and corrects it with the signed-overflow condition. A small decoder turns the operation code into a set of strobes. Those strobes steer the operand inversion and choose which of the adder, AND, OR, XOR or compare paths reaches the output.

Top module: `sharedAdderAlu`

## Requirements
- R1: With opSel = 3'b000 (add), result equals (opA + opB) modulo 2^32.
- R2: With opSel = 3'b001 (subtract), result equals (opA - opB) modulo 2^32, formed as opA + ~opB + 1 in the shared adder.
- R3: With opSel = 3'b010, 3'b011 or 3'b100, result is the bitwise AND, OR or XOR of opA and opB respectively.
- R4: With opSel = 3'b101 (signed less-than), result bit 0 is 1 exactly when opA < opB as two's-complement numbers. This holds also when the difference overflows. Result bits 31 to 1 are 0.
- R5: With opSel = 3'b110 or 3'b111, result is 0 whatever the operands are.
- R6: zero is 1 exactly when all 32 bits of result are 0, for every operation code.
- R7: Adding 32'hFFFFFFFF and 32'h00000001 gives result 32'h00000000 and zero = 1, and the carry out of the last adder stage is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opSel | input | 3 | Operation code |
| result | output | 32 | Selected operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Two functions can take effect in the same evaluation. The first pair is the zero flag and an arithmetic result. Wrapping 32'hFFFFFFFF + 1 and subtracting an operand from itself both give zero = 1 together with the sum or difference. The second pair is a compare and the adder's overflow correction: comparing 32'h80000000 with 32'h7FFFFFFF puts the raw sign bit and the overflow term into conflict. The scoreboard checks both outputs of every such vector against values that the bench derives from the operation definitions. The bound checker also confirms the final carry during every add.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int unsigned OP_WIDTH = 3;

  typedef enum logic [OP_WIDTH-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_SLT = 3'b101
  } aluOpE;

  // Strobes from the decoder into the datapath; the select strobes are one-hot or all low.
  typedef struct packed {
    logic invertB;
    logic carryIn;
    logic useSum;
    logic useAnd;
    logic useOr;
    logic useXor;
    logic useLess;
  } aluStrobesT;
endpackage

// File: rtl/aluHalfAdder.sv
module aluHalfAdder (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/aluFullAdder.sv
module aluFullAdder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic partSum;
  logic carryLow;
  logic carryHigh;

  aluHalfAdder haLow  (.x(x),       .y(y),   .s(partSum), .c(carryLow));
  aluHalfAdder haHigh (.x(partSum), .y(cin), .s(s),       .c(carryHigh));

  assign cout = carryLow | carryHigh;
endmodule

// File: rtl/aluRippleAdder.sv
module aluRippleAdder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH:0] carryChain;

  assign carryChain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : gStage
    aluFullAdder fa (
      .x   (x[i]),
      .y   (y[i]),
      .cin (carryChain[i]),
      .s   (sum[i]),
      .cout(carryChain[i+1])
    );
  end

  assign cout = carryChain[WIDTH];
endmodule

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [OP_WIDTH-1:0] opSel,
  output aluStrobesT          strobes
);
  always_comb begin
    strobes = '0;
    unique case (opSel)
      OP_ADD: strobes.useSum = 1'b1;
      OP_SUB: begin
        strobes.useSum  = 1'b1;
        strobes.invertB = 1'b1;
        strobes.carryIn = 1'b1;
      end
      OP_AND: strobes.useAnd = 1'b1;
      OP_OR:  strobes.useOr  = 1'b1;
      OP_XOR: strobes.useXor = 1'b1;
      OP_SLT: begin
        strobes.useLess = 1'b1;
        strobes.invertB = 1'b1;
        strobes.carryIn = 1'b1;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobesT       strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] addendB;
  logic [WIDTH-1:0] sum;
  logic             signedOverflow;
  logic             lessThan;
  logic [WIDTH-1:0] lessWord;

  assign addendB = opB ^ {WIDTH{strobes.invertB}};

  aluRippleAdder #(.WIDTH(WIDTH)) adder (
    .x   (opA),
    .y   (addendB),
    .cin (strobes.carryIn),
    .sum (sum),
    .cout(carryOut)
  );

  // Overflow of a - b: operand signs differ and the difference sign left opA's sign.
  assign signedOverflow = (opA[MSB] != opB[MSB]) && (sum[MSB] != opA[MSB]);
  assign lessThan       = sum[MSB] ^ signedOverflow;
  assign lessWord       = {{(WIDTH-1){1'b0}}, lessThan};

  assign result = ({WIDTH{strobes.useSum}}  & sum)
                | ({WIDTH{strobes.useAnd}}  & (opA & opB))
                | ({WIDTH{strobes.useOr}}   & (opA | opB))
                | ({WIDTH{strobes.useXor}}  & (opA ^ opB))
                | ({WIDTH{strobes.useLess}} & lessWord);
endmodule

// File: rtl/sharedAdderAlu.sv
module sharedAdderAlu
  import aluPkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]    opA,
  input  logic [WIDTH-1:0]    opB,
  input  logic [OP_WIDTH-1:0] opSel,
  output logic [WIDTH-1:0]    result,
  output logic                zero
);
  aluStrobesT strobes;
  logic       carryOut;

  aluControl ctrl (
    .opSel  (opSel),
    .strobes(strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut)
  );

  assign zero = ~|result;
endmodule

// File: rtl/aluCheck.sv
module aluCheck #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             carryOut
);
  logic [WIDTH:0] wideSum;
  assign wideSum = {1'b0, opA} + {1'b0, opB};

  always_comb begin
    if (opSel == 3'b000) begin
      AST_ADD_SUM: assert (result == wideSum[WIDTH-1:0]) else $error("add mismatch"); // R1
      AST_ADD_CARRY: assert (carryOut == wideSum[WIDTH]) else $error("carry mismatch"); // R7
    end
    if (opSel == 3'b001) begin
      AST_SUB_DIFF: assert (result == opA - opB) else $error("sub mismatch"); // R2
    end
    if (opSel == 3'b101) begin
      AST_SLT_VALUE: assert (result[0] == ($signed(opA) < $signed(opB))) else $error("slt mismatch"); // R4
      AST_SLT_UPPER: assert ($countones(result[WIDTH-1:1]) == 0) else $error("slt upper bits"); // R4
    end
    if (opSel[2:1] == 2'b11) begin
      AST_UNUSED_CODE: assert ($countones(result) == 0) else $error("unused code nonzero"); // R5
    end
    AST_ZERO_FLAG: assert (zero == ($countones(result) == 0)) else $error("zero flag mismatch"); // R6
  end
endmodule

bind sharedAdderAlu aluCheck #(.WIDTH(WIDTH)) chk (
  .opA     (opA),
  .opB     (opB),
  .opSel   (opSel),
  .result  (result),
  .zero    (zero),
  .carryOut(carryOut)
);

// File: tb/sharedAdderAlu_test.sv
module sharedAdderAlu_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct {
    logic [31:0] expRes;
    logic        expZero;
    string       tag;
  } expItemT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opSel = '0;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  expItemT scoreQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sharedAdderAlu uut (
    .opA   (opA),
    .opB   (opB),
    .opSel (opSel),
    .result(result),
    .zero  (zero)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] op);
    case (op)
      3'b000:  return a + b;
      3'b001:  return a - b;
      3'b010:  return a & b;
      3'b011:  return a | b;
      3'b100:  return a ^ b;
      3'b101:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] op, input string tag);
    expItemT it;
    @(posedge clk);
    opA   = a;
    opB   = b;
    opSel = op;
    it.expRes  = model(a, b, op);
    it.expZero = (it.expRes == 32'd0);
    it.tag     = tag;
    scoreQ.push_back(it);
  endtask

  // Monitor: sample at the falling edge, half a period after the drive.
  always @(negedge clk) begin
    if (!rst && scoreQ.size() > 0) begin
      expItemT it;
      it = scoreQ.pop_front();
      checks++;
      if (result !== it.expRes) begin
        failures++;
        $display("FAIL %s result actual=%h expected=%h", it.tag, result, it.expRes);
      end
      checks++;
      if (zero !== it.expZero) begin
        failures++;
        $display("FAIL %s zero actual=%b expected=%b", it.tag, zero, it.expZero);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state after reset: add of zeros. Checks R1 and R6.
    drive(32'h0, 32'h0, 3'b000, "R6 idle");
    // R1 add
    drive(32'd5, 32'd7, 3'b000, "R1");
    drive(32'h7FFFFFFF, 32'h1, 3'b000, "R1");
    drive(32'h12345678, 32'h9ABCDEF0, 3'b000, "R1");
    // R7 wraparound
    drive(32'hFFFFFFFF, 32'h1, 3'b000, "R7");
    // R2 subtract
    drive(32'd10, 32'd3, 3'b001, "R2");
    drive(32'd0, 32'd1, 3'b001, "R2");
    drive(32'hDEADBEEF, 32'hDEADBEEF, 3'b001, "R2 R6");
    drive(32'h80000000, 32'h1, 3'b001, "R2");
    // R3 logic
    drive(32'hF0F0F0F0, 32'hFF00FF00, 3'b010, "R3 and");
    drive(32'hAAAA0000, 32'h5555FFFF, 3'b010, "R3 and R6");
    drive(32'hF0F0F0F0, 32'h0F0F0000, 3'b011, "R3 or");
    drive(32'h0, 32'h0, 3'b011, "R3 or R6");
    drive(32'hFFFF0000, 32'hF0F0F0F0, 3'b100, "R3 xor");
    drive(32'h13572468, 32'h13572468, 3'b100, "R3 xor R6");
    // R4 signed compare
    drive(32'hFFFFFFFF, 32'h1, 3'b101, "R4");
    drive(32'h1, 32'hFFFFFFFF, 3'b101, "R4");
    drive(32'h80000000, 32'h7FFFFFFF, 3'b101, "R4 overflow");
    drive(32'h7FFFFFFF, 32'h80000000, 3'b101, "R4 overflow");
    drive(32'd42, 32'd42, 3'b101, "R4 equal");
    drive(32'd3, 32'd9, 3'b101, "R4");
    // R5 unused codes
    drive(32'hFFFFFFFF, 32'h12345678, 3'b110, "R5");
    drive(32'hABCDEF01, 32'hFFFFFFFF, 3'b111, "R5");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule